// File: doc/BRIEF.md
# Multi-Core Reset and Boot Controller

This block is a small register file on a 32-bit bus. Software uses it to start and stop the secondary processor cores, to pulse a reset into any core, and to pulse a reset into either of two display peripherals. Every register sits in a 4 KB window and is selected by its word index, which is the byte address shifted right by two. Only aligned word accesses decode.

A write to the control register is compared against the value already stored there. Only the bits that differ cause an action. When a core's enable bit rises, that core gets a start pulse, and its entry address and argument are taken from its own pair of general-purpose registers, which are always presented on the boot buses. When the enable bit falls, the core gets a stop pulse. A changed core reset bit produces a one-cycle reset pulse into that core. The core reset bits then clear themselves one cycle later. The display reset bits never hold a 1: a toggle on one of them is acknowledged at once.

Top module: `core_boot_ctl`

## Requirements
- R1: After reset, word index 0 (control) reads 0x521, index 2 reads 0x1 and index 4 reads 0x1F. Every other index reads 0, and all pulse and run outputs are 0.
- R2: The word index is `addr[11:2]`, and indices 0 to 15 are mapped. Index 0 is control, 1 is boot-mode A, 2 is reset status, 3 is interrupt status, 4 is interrupt mask and 5 is boot-mode B. GPR n is at index 5+n (n = 1..10). A write to any mapped index other than 0 stores the written word, and a read returns it with no wait cycle.
- R3: A read of an index of 16 or more, or of an address with `addr[1:0]` not 0, returns 0. A write to such an address changes no register.
- R4: A 0→1 change of control bit 21+c (core c = 1..3) gives a one-cycle pulse on `core_start[c-1]` in the cycle after the write. `core_run[c-1]` follows the stored bit.
- R5: A 1→0 change of control bit 21+c gives a one-cycle pulse on `core_stop[c-1]` in the cycle after the write.
- R6: When core c's enable bit changes, no pulse appears on `core_rst[c]` from that write. Core c's reset bit (bit 13+c) reads 0 from the second cycle after the write.
- R7: A change of control bit 13+i (i = 0..3) gives a one-cycle pulse on `core_rst[i]` in the cycle after the write. The bit reads back as written in that cycle and reads 0 from the next cycle on.
- R8: A control write in which no bit changes produces no pulse of any kind.
- R9: A change of control bit 3 pulses `periph_rst[0]`, and a change of bit 12 pulses `periph_rst[1]`, in the cycle after the write. The stored bit reads 0 at once.
- R10: `boot_addr[s*32 +: 32]` shows GPR(2s+3) and `boot_arg[s*32 +: 32]` shows GPR(2s+4) for secondary core s+1 (s = 0..2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte address within the window |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| core_run | output | 3 | Stored enable bits of cores 1 to 3 |
| core_start | output | 3 | Start pulse per secondary core |
| core_stop | output | 3 | Stop pulse per secondary core |
| core_rst | output | 4 | Reset pulse per core 0 to 3 |
| periph_rst | output | 2 | Display peripheral reset pulses |
| boot_addr | output | 96 | Entry address per secondary core |
| boot_arg | output | 96 | Context argument per secondary core |

## Verification
The bench builds the block with its defaults: a 12-bit address and 32-bit data. With these values, all 1024 word indices of the window can be swept. Every index beyond the sixteenth is written with all ones and read back as zero, and then the mapped registers are checked to be unchanged. Each core's enable rise and fall is tested, each reset bit is tested singly and all together, and each display bit is tested twice in a row. A mixed write is tested as well. In every case the expected pulse pattern and the readback before and after the deferred clear are derived arithmetically from the bit layout.

// File: rtl/core_boot_pkg.sv
package core_boot_pkg;
  localparam int NUM_REGS   = 16;
  localparam int IDX_W      = $clog2(NUM_REGS);
  localparam int NUM_CORES  = 4;
  localparam int NUM_SEC    = NUM_CORES - 1;
  localparam int NUM_PERIPH = 2;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_RSTAT  = 2;
  localparam int IDX_IMASK  = 4;
  localparam int IDX_GPR0   = 5;   // GPR n lives at IDX_GPR0 + n

  localparam int RST_BASE   = 13;  // core i reset bit
  localparam int EN_BASE    = 22;  // core 1 enable bit, cores 2,3 follow

  localparam logic [31:0] CTRL_INIT  = 32'h0000_0521;
  localparam logic [31:0] RSTAT_INIT = 32'h0000_0001;
  localparam logic [31:0] IMASK_INIT = 32'h0000_001F;

  function automatic int periph_bit(input int j);
    return (j == 0) ? 3 : 12;
  endfunction

  function automatic int entry_idx(input int s);
    return IDX_GPR0 + 3 + 2 * s;
  endfunction

  function automatic logic [31:0] init_value(input int idx);
    case (idx)
      IDX_CTRL:  return CTRL_INIT;
      IDX_RSTAT: return RSTAT_INIT;
      IDX_IMASK: return IMASK_INIT;
      default:   return 32'h0;
    endcase
  endfunction
endpackage

// File: rtl/cbc_addr_dec.sv
module cbc_addr_dec
  import core_boot_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              ctrl_we,
  output logic              reg_we
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              aligned;

  assign widx    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    hit     = aligned && (widx < WIDX_W'(NUM_REGS));
    idx     = widx[IDX_W-1:0];
    ctrl_we = wr_en && hit && (idx == IDX_W'(IDX_CTRL));
    reg_we  = wr_en && hit && (idx != IDX_W'(IDX_CTRL));
  end
endmodule

// File: rtl/cbc_regfile.sv
module cbc_regfile
  import core_boot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDX_W-1:0]               idx,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
  assign regs_o[0] = '0;

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    localparam logic [DATA_W-1:0] INIT = DATA_W'(init_value(g));
    logic              en;
    logic [DATA_W-1:0] q;
    logic [DATA_W-1:0] d;

    always_comb begin
      en = we && (idx == IDX_W'(g));
      d  = en ? wdata : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= INIT;
      else        q <= d;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import core_boot_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     ctrl_o,
  output logic [NUM_SEC-1:0]    run_o,
  output logic [NUM_SEC-1:0]    start_o,
  output logic [NUM_SEC-1:0]    stop_o,
  output logic [NUM_CORES-1:0]  core_rst_o,
  output logic [NUM_PERIPH-1:0] periph_rst_o
);
  logic [DATA_W-1:0]     ctrl_q, ctrl_d;
  logic [NUM_CORES-1:0]  pend_q, pend_d;
  logic [NUM_SEC-1:0]    start_q, start_d, stop_q, stop_d;
  logic [NUM_CORES-1:0]  rst_q, rst_d;
  logic [NUM_PERIPH-1:0] per_q, per_d;

  logic [DATA_W-1:0]     chg;
  logic [DATA_W-1:0]     wval;
  logic [DATA_W-1:0]     clr_mask;
  logic [NUM_CORES-1:0]  en_tog;

  always_comb begin
    chg      = ctrl_q ^ wdata;
    en_tog   = '0;
    start_d  = '0;
    stop_d   = '0;
    for (int s = 0; s < NUM_SEC; s++) begin
      en_tog[s+1] = we && chg[EN_BASE+s];
      start_d[s]  = en_tog[s+1] && wdata[EN_BASE+s];
      stop_d[s]   = en_tog[s+1] && !wdata[EN_BASE+s];
    end
    for (int i = 0; i < NUM_CORES; i++) begin
      rst_d[i]  = we && chg[RST_BASE+i] && !en_tog[i];
      pend_d[i] = rst_d[i] || en_tog[i];
    end
    wval = wdata;
    for (int j = 0; j < NUM_PERIPH; j++) begin
      per_d[j] = we && chg[periph_bit(j)];
      if (chg[periph_bit(j)]) wval[periph_bit(j)] = 1'b0;
    end
    clr_mask = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      clr_mask[RST_BASE+i] = pend_q[i];
    end
    ctrl_d = (we ? wval : ctrl_q) & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= DATA_W'(CTRL_INIT);
      pend_q  <= '0;
      start_q <= '0;
      stop_q  <= '0;
      rst_q   <= '0;
      per_q   <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      pend_q  <= pend_d;
      start_q <= start_d;
      stop_q  <= stop_d;
      rst_q   <= rst_d;
      per_q   <= per_d;
    end
  end

  assign ctrl_o       = ctrl_q;
  assign run_o        = ctrl_q[EN_BASE +: NUM_SEC];
  assign start_o      = start_q;
  assign stop_o       = stop_q;
  assign core_rst_o   = rst_q;
  assign periph_rst_o = per_q;
endmodule

// File: rtl/core_boot_ctl.sv
module core_boot_ctl
  import core_boot_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      wr_en,
  input  logic [DATA_W-1:0]         wdata,
  output logic [DATA_W-1:0]         rdata,
  output logic [NUM_SEC-1:0]        core_run,
  output logic [NUM_SEC-1:0]        core_start,
  output logic [NUM_SEC-1:0]        core_stop,
  output logic [NUM_CORES-1:0]      core_rst,
  output logic [NUM_PERIPH-1:0]     periph_rst,
  output logic [NUM_SEC*DATA_W-1:0] boot_addr,
  output logic [NUM_SEC*DATA_W-1:0] boot_arg
);
  logic                            hit;
  logic [IDX_W-1:0]                idx;
  logic                            ctrl_we;
  logic                            reg_we;
  logic [DATA_W-1:0]               ctrl_val;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [NUM_REGS-1:0][DATA_W-1:0] view;

  cbc_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr    (addr),
    .wr_en   (wr_en),
    .hit     (hit),
    .idx     (idx),
    .ctrl_we (ctrl_we),
    .reg_we  (reg_we)
  );

  cbc_regfile #(.DATA_W(DATA_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (reg_we),
    .idx    (idx),
    .wdata  (wdata),
    .regs_o (regs)
  );

  cbc_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .we           (ctrl_we),
    .wdata        (wdata),
    .ctrl_o       (ctrl_val),
    .run_o        (core_run),
    .start_o      (core_start),
    .stop_o       (core_stop),
    .core_rst_o   (core_rst),
    .periph_rst_o (periph_rst)
  );

  always_comb begin
    view           = regs;
    view[IDX_CTRL] = ctrl_val;
    rdata          = hit ? view[idx] : '0;
  end

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_boot
    assign boot_addr[s*DATA_W +: DATA_W] = regs[entry_idx(s)];
    assign boot_arg[s*DATA_W +: DATA_W]  = regs[entry_idx(s) + 1];
  end
endmodule

// File: rtl/core_boot_ctl_chk.sv
module core_boot_ctl_chk
  import core_boot_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [ADDR_W-1:0]     addr,
  input logic                  wr_en,
  input logic [DATA_W-1:0]     rdata,
  input logic [DATA_W-1:0]     ctrl_val,
  input logic [NUM_SEC-1:0]    core_run,
  input logic [NUM_SEC-1:0]    core_start,
  input logic [NUM_SEC-1:0]    core_stop,
  input logic [NUM_CORES-1:0]  core_rst,
  input logic [NUM_PERIPH-1:0] periph_rst
);
  a_r3_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((addr[ADDR_W-1:2] >= (ADDR_W-2)'(NUM_REGS)) || (addr[1:0] != 2'b00)) |-> (rdata == '0));

  a_r8_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((|core_rst) || (|core_start) || (|core_stop) || (|periph_rst)) |-> $past(wr_en));

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    a_r7_rst_bit_clears: assert property (@(posedge clk) disable iff (!rst_n)
      core_rst[i] |=> !ctrl_val[RST_BASE+i]);
  end

  for (genvar s = 0; s < NUM_SEC; s++) begin : g_sec
    a_r4_start_sets_run: assert property (@(posedge clk) disable iff (!rst_n)
      core_start[s] |-> core_run[s]);
    a_r5_stop_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
      core_stop[s] |-> !core_run[s]);
    a_r6_no_rst_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (core_start[s] || core_stop[s]) |-> !core_rst[s+1]);
    a_r6_enable_clears_rst: assert property (@(posedge clk) disable iff (!rst_n)
      (core_start[s] || core_stop[s]) |=> !ctrl_val[RST_BASE+s+1]);
  end

  for (genvar j = 0; j < NUM_PERIPH; j++) begin : g_per
    a_r9_periph_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst[j] |-> !ctrl_val[periph_bit(j)]);
  end
endmodule

bind core_boot_ctl core_boot_ctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .rdata      (rdata),
  .ctrl_val   (ctrl_val),
  .core_run   (core_run),
  .core_start (core_start),
  .core_stop  (core_stop),
  .core_rst   (core_rst),
  .periph_rst (periph_rst)
);

// File: tb/core_boot_ctl_tb.sv
module core_boot_ctl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [2:0]    core_run, core_start, core_stop;
  logic [3:0]    core_rst;
  logic [1:0]    periph_rst;
  logic [95:0]   boot_addr, boot_arg;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_ctrl;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_boot_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .core_run(core_run), .core_start(core_start),
    .core_stop(core_stop), .core_rst(core_rst), .periph_rst(periph_rst),
    .boot_addr(boot_addr), .boot_arg(boot_arg)
  );

  function automatic logic [31:0] pat(input int idx);
    return 32'h1357_9BDF * (idx + 1) ^ 32'h00A0_0000;
  endfunction

  function automatic logic [31:0] init_exp(input int idx);
    case (idx)
      0: return 32'h521;
      2: return 32'h1;
      4: return 32'h1F;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; wr_en = 1'b0;
    #1;
    v = rdata;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 16; i++) begin
      rd(AW'(i * 4), v);
      chk("R1 init", v, init_exp(i));
    end
    chk("R1 pulses", {22'b0, core_run, core_start, core_stop, core_rst, periph_rst}, 32'h0);
    m_ctrl = 32'h521;

    // R2 mapped register sweep, R10 boot buses
    for (int i = 1; i < 16; i++) wr(AW'(i * 4), pat(i));
    for (int i = 1; i < 16; i++) begin
      rd(AW'(i * 4), v);
      chk("R2 readback", v, pat(i));
    end
    for (int s = 0; s < 3; s++) begin
      chk("R10 boot_addr", boot_addr[s*32 +: 32], pat(5 + 2*s + 3));
      chk("R10 boot_arg",  boot_arg[s*32 +: 32],  pat(5 + 2*s + 4));
    end

    // R3 unmapped indices and unaligned access
    for (int i = 16; i < 1024; i++) begin
      wr(AW'(i * 4), 32'hFFFF_FFFF);
      chk("R3 unmapped read", rdata, 32'h0);
    end
    wr(AW'(4 | 1), 32'hDEAD_BEEF);
    chk("R3 unaligned read", rdata, 32'h0);
    for (int i = 0; i < 16; i++) begin
      rd(AW'(i * 4), v);
      chk("R3 regs unchanged", v, (i == 0) ? m_ctrl : pat(i));
    end

    // R4 R5 R6 enable rise and fall per core
    for (int c = 1; c <= 3; c++) begin
      v = m_ctrl | (32'h1 << (21 + c)) | (32'h1 << (13 + c));
      wr(AW'(0), v);
      chk("R4 start pulse", {29'b0, core_start}, 32'h1 << (c - 1));
      chk("R4 run", {29'b0, core_run}, {29'b0, v[24:22]});
      chk("R6 no rst pulse", {28'b0, core_rst}, 32'h0);
      chk("R6 bit as written", rdata, v);
      next_cycle();
      chk("R4 start ends", {29'b0, core_start}, 32'h0);
      m_ctrl = v & ~(32'h1 << (13 + c));
      chk("R6 rst bit cleared", rdata, m_ctrl);
      v = m_ctrl & ~(32'h1 << (21 + c));
      wr(AW'(0), v);
      chk("R5 stop pulse", {29'b0, core_stop}, 32'h1 << (c - 1));
      chk("R5 run cleared", {29'b0, core_run}, 32'h0);
      chk("R6 no rst on stop", {28'b0, core_rst}, 32'h0);
      next_cycle();
      chk("R5 stop ends", {29'b0, core_stop}, 32'h0);
      m_ctrl = v;
    end

    // R7 core reset pulses
    for (int i = 0; i < 4; i++) begin
      v = m_ctrl | (32'h1 << (13 + i));
      wr(AW'(0), v);
      chk("R7 rst pulse", {28'b0, core_rst}, 32'h1 << i);
      chk("R7 bit as written", rdata, v);
      next_cycle();
      chk("R7 pulse ends", {28'b0, core_rst}, 32'h0);
      chk("R7 bit cleared", rdata, m_ctrl);
    end
    v = m_ctrl | (32'hF << 13);
    wr(AW'(0), v);
    chk("R7 all rst", {28'b0, core_rst}, 32'hF);
    next_cycle();
    chk("R7 all cleared", rdata, m_ctrl);

    // mixed: core 1 enable with core 2 reset
    v = m_ctrl | (32'h1 << 22) | (32'h1 << 15);
    wr(AW'(0), v);
    chk("R4 mixed start", {29'b0, core_start}, 32'h1);
    chk("R7 mixed rst", {28'b0, core_rst}, 32'h4);
    next_cycle();
    m_ctrl = v & ~(32'h1 << 15);
    chk("R7 mixed cleared", rdata, m_ctrl);

    // R9 display resets
    for (int rep = 0; rep < 2; rep++) begin
      wr(AW'(0), m_ctrl | (32'h1 << 3));
      chk("R9 periph0 pulse", {30'b0, periph_rst}, 32'h1);
      chk("R9 bit3 zero", rdata, m_ctrl);
    end
    wr(AW'(0), m_ctrl | (32'h1 << 12));
    chk("R9 periph1 pulse", {30'b0, periph_rst}, 32'h2);
    chk("R9 bit12 zero", rdata, m_ctrl);
    wr(AW'(0), m_ctrl | (32'h1 << 12) | (32'h1 << 3));
    chk("R9 both pulse", {30'b0, periph_rst}, 32'h3);
    next_cycle();
    chk("R9 pulse ends", {30'b0, periph_rst}, 32'h0);

    // R8 write without change
    wr(AW'(0), m_ctrl);
    chk("R8 no pulses", {19'b0, core_start, core_stop, core_rst, periph_rst}, 32'h0);
    chk("R8 value kept", rdata, m_ctrl);
    w = m_ctrl;
    rd(AW'(0), v);
    chk("R8 value later", v, w);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule